// File: doc/BRIEF.md
# Edge-Count Capture Timer

This block is one timer channel that counts edges on an external capture input. The input passes through a synchronizer and then an edge detector. The edge detector can qualify rising edges, falling edges or both. Each qualifying edge moves a 24-bit counter one step. The 24-bit value is a 16-bit count with an 8-bit prescale extension above it. When the counter reaches a programmed match value, the block raises a capture-match status bit. That bit, gated by a mask, drives a single interrupt line.

The counter runs in one of two directions:

- **Down.** The counter starts at the load value. After (load − match) qualifying edges it reaches the match value. It then reloads from the load value, clears its own run bit, and ignores every later edge until software sets the run bit again.
- **Up.** The counter starts at zero and counts up to the match value. On match it returns to zero and keeps running.

A load-update control bit selects when a new load value takes effect. When the bit is clear, the value takes effect on the next clock. When the bit is set, the value is held back until the next match reload.

Software uses a small word-wide register port. Writes are synchronous. Reads are combinational.

Top module: `edge_count_timer`

## Requirements
- R1: In down mode, with run set, the counter decrements once per qualifying edge. A match event occurs on the edge that brings it to the match value (address 2), which is exactly (load − match) edges after the count was loaded.
- R2: On a down-mode match, the counter reloads to the active load value and the run bit (control bit 0, address 0) reads 0 afterwards.
- R3: While run is clear, edges leave the counter unchanged. Setting run again resumes counting from the reloaded value.
- R4: In up mode (control bit 1 = 1), a change of direction sets the counter to zero. On the edge that reaches the match value, the counter returns to 0, the status is set, and run stays 1.
- R5: While run is set, writes to the load register (address 1), the match register (address 2) and the configuration bits of the control register are ignored. Only the run bit of the control register can be written while running.
- R6: A match sets the status bit (address 4, bit 0). The `irq` output equals status AND mask (address 5, bit 0). Writing 1 to bit 0 of address 6 clears the status.
- R7: The edge select in control bits 3:2 works as follows: 0 counts rising edges, 1 counts falling edges, and 2 or 3 count both edges.
- R8: With control bit 4 clear, a load write sets the counter on the next clock: to the load value in down mode, or to 0 in up mode. With bit 4 set, the value is held and becomes active at the next match reload.
- R9: With the capture input held constant, the counter does not change over any number of cycles.
- R10: Address 3 reads the live 24-bit combined count, with the prescale extension in bits 23:16.
- R11: If a match event and a write-one-to-clear land in the same cycle, the status bit ends set.
- R12: One transition of the capture input produces exactly one count step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_in | input | 1 | Asynchronous capture input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1 load, 2 match, 3 count, 4 status, 5 mask, 6 clear) |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Combinational read data for `reg_addr` |
| irq | output | 1 | Masked capture-match interrupt |

## Verification
The hardest situation to reach is a match event that falls in the same clock as a write-one-to-clear. The capture input passes through two synchronizer flops and an edge register before it reaches the counter. The bench therefore arms the counter one edge short of its match value, raises the capture input, and counts two falling clock edges. It then drives the clear write, so that the write lands in the cycle in which the synchronized edge reaches the counter. The deferred-load path is similarly hidden: its effect only shows at the next reload. The bench therefore reads the count both before and after a match to catch it.

// File: rtl/ect_pkg.sv
package ect_pkg;

   typedef enum logic [1:0] {
      EDGE_RISE  = 2'd0,
      EDGE_FALL  = 2'd1,
      EDGE_BOTH  = 2'd2,
      EDGE_BOTH2 = 2'd3
   } edge_sel_e;

   localparam logic [2:0] ADR_CTRL   = 3'd0;
   localparam logic [2:0] ADR_LOAD   = 3'd1;
   localparam logic [2:0] ADR_MATCH  = 3'd2;
   localparam logic [2:0] ADR_COUNT  = 3'd3;
   localparam logic [2:0] ADR_STATUS = 3'd4;
   localparam logic [2:0] ADR_MASK   = 3'd5;
   localparam logic [2:0] ADR_CLEAR  = 3'd6;

   localparam int CTL_RUN   = 0;
   localparam int CTL_UP    = 1;
   localparam int CTL_SEL_L = 2;
   localparam int CTL_DEFER = 4;

endpackage

// File: rtl/ect_edge_detect.sv
module ect_edge_detect
   import ect_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  edge_sel_e sel,
   output logic      hit
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ect_edge_detect: SYNC_STAGES must be at least 2");
   end

   // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its previous value
   logic [SYNC_STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-1:0], pin};
   end

   logic rise, fall;
   assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
   assign fall = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];

   always_comb begin
      unique case (sel)
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         default:   hit = rise | fall;
      endcase
   end

endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
   parameter int CNT_W = 16,
   parameter int PRE_W = 8,
   localparam int TOT_W = CNT_W + PRE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,        // qualifying edge while running
   input  logic             dir_up,     // current direction
   input  logic             dir_chg,    // direction flips this cycle
   input  logic             defer,
   input  logic             load_wr,
   input  logic [TOT_W-1:0] load_data,
   input  logic [TOT_W-1:0] match_val,
   output logic [TOT_W-1:0] count,
   output logic             match_evt
);

   if (CNT_W < 2 || PRE_W < 0) begin : g_bad_width
      $error("ect_counter: bad width parameters");
   end

   logic [TOT_W-1:0] cnt_q, act_q, pend_q, nxt, reload;
   logic             pend_vld_q;

   assign nxt       = dir_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
   assign match_evt = hit && (nxt == match_val);
   assign reload    = pend_vld_q ? pend_q : act_q;
   assign count     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         act_q      <= '0;
         pend_q     <= '0;
         pend_vld_q <= 1'b0;
      end else begin
         if (load_wr) begin
            if (defer) begin
               pend_q     <= load_data;
               pend_vld_q <= 1'b1;
            end else begin
               act_q      <= load_data;
               pend_vld_q <= 1'b0;
               cnt_q      <= dir_up ? '0 : load_data;
            end
         end
         if (dir_chg) begin
            cnt_q <= dir_up ? act_q : '0;  // flipping to the opposite direction
         end
         if (hit) begin
            if (match_evt) begin
               if (pend_vld_q) begin
                  act_q      <= pend_q;
                  pend_vld_q <= 1'b0;
               end
               cnt_q <= dir_up ? '0 : reload;
            end else begin
               cnt_q <= nxt;
            end
         end
      end
   end

endmodule

// File: rtl/ect_regs.sv
module ect_regs
   import ect_pkg::*;
#(
   parameter int TOT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [2:0]       reg_addr,
   input  logic [TOT_W-1:0] reg_wdata,
   output logic [TOT_W-1:0] reg_rdata,
   input  logic [TOT_W-1:0] count,
   input  logic             match_evt,
   output logic             run,
   output logic             dir_up,
   output edge_sel_e        sel,
   output logic             defer,
   output logic             dir_chg,
   output logic             load_wr,
   output logic [TOT_W-1:0] match_val,
   output logic             status,
   output logic             mask
);

   if (TOT_W < CTL_DEFER + 1) begin : g_bad_data
      $error("ect_regs: data path too narrow for control bits");
   end

   logic wr_ctrl, wr_match, wr_mask, wr_clr;

   assign wr_ctrl  = reg_wr && reg_addr == ADR_CTRL;
   assign wr_match = reg_wr && reg_addr == ADR_MATCH && !run;
   assign wr_mask  = reg_wr && reg_addr == ADR_MASK;
   assign wr_clr   = reg_wr && reg_addr == ADR_CLEAR && reg_wdata[0];
   assign load_wr  = reg_wr && reg_addr == ADR_LOAD && !run;
   assign dir_chg  = wr_ctrl && !run && (reg_wdata[CTL_UP] != dir_up);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         dir_up    <= 1'b0;
         sel       <= EDGE_RISE;
         defer     <= 1'b0;
         match_val <= '0;
         status    <= 1'b0;
         mask      <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            run <= reg_wdata[CTL_RUN];
            if (!run) begin
               dir_up <= reg_wdata[CTL_UP];
               sel    <= edge_sel_e'(reg_wdata[CTL_SEL_L +: 2]);
               defer  <= reg_wdata[CTL_DEFER];
            end
         end
         if (match_evt && !dir_up) run <= 1'b0;  // down-count auto-stop
         if (wr_match) match_val <= reg_wdata;
         if (wr_mask)  mask      <= reg_wdata[0];
         if (match_evt)   status <= 1'b1;        // new event beats clear
         else if (wr_clr) status <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADR_CTRL: begin
            reg_rdata[CTL_RUN]          = run;
            reg_rdata[CTL_UP]           = dir_up;
            reg_rdata[CTL_SEL_L +: 2]   = sel;
            reg_rdata[CTL_DEFER]        = defer;
         end
         ADR_MATCH:  reg_rdata    = match_val;
         ADR_COUNT:  reg_rdata    = count;
         ADR_STATUS: reg_rdata[0] = status;
         ADR_MASK:   reg_rdata[0] = mask;
         default:    reg_rdata    = '0;
      endcase
   end

endmodule

// File: rtl/edge_count_timer.sv
module edge_count_timer
   import ect_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int TOT_W = CNT_W + PRE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_in,
   input  logic             reg_wr,
   input  logic [2:0]       reg_addr,
   input  logic [TOT_W-1:0] reg_wdata,
   output logic [TOT_W-1:0] reg_rdata,
   output logic             irq
);

   logic             run_q, dir_up, defer, dir_chg, load_wr;
   logic             status_q, mask_q, edge_hit, edge_ok, match_evt;
   edge_sel_e        sel;
   logic [TOT_W-1:0] match_val, count_q;

   ect_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (cap_in),
      .sel   (sel),
      .hit   (edge_hit)
   );

   assign edge_ok = edge_hit && run_q;

   ect_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (edge_ok),
      .dir_up    (dir_up),
      .dir_chg   (dir_chg),
      .defer     (defer),
      .load_wr   (load_wr),
      .load_data (reg_wdata),
      .match_val (match_val),
      .count     (count_q),
      .match_evt (match_evt)
   );

   ect_regs #(.TOT_W(TOT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .count     (count_q),
      .match_evt (match_evt),
      .run       (run_q),
      .dir_up    (dir_up),
      .sel       (sel),
      .defer     (defer),
      .dir_chg   (dir_chg),
      .load_wr   (load_wr),
      .match_val (match_val),
      .status    (status_q),
      .mask      (mask_q)
   );

   assign irq = status_q & mask_q;

endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
   parameter int TOT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             run,
   input logic             dir_up,
   input logic             hit,
   input logic             match_evt,
   input logic             status,
   input logic [TOT_W-1:0] count
);

   // R2: a down-count match stops the channel
   assert_auto_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && !dir_up) |=> !run);

   // R4: an up-count match keeps the channel running
   assert_up_keeps_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && dir_up && !reg_wr) |=> run);

   // R6 / R11: a match always leaves status set
   assert_status_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> status);

   // R3: a stopped channel's count moves only through register writes
   assert_idle_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !reg_wr) |=> $stable(count));

   // R9: without a qualifying edge or a write, the count holds
   assert_hold_no_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !reg_wr) |=> $stable(count));

endmodule

bind edge_count_timer ect_checker #(.TOT_W(TOT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .run       (run_q),
   .dir_up    (dir_up),
   .hit       (edge_ok),
   .match_evt (match_evt),
   .status    (status_q),
   .count     (count_q)
);

// File: tb/tb_edge_count_timer.sv
module tb_edge_count_timer;

   localparam int CLK_PERIOD = 10;
   localparam int W = 24;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cap_in = 1'b0;
   logic         reg_wr = 1'b0;
   logic [2:0]   reg_addr = 3'd0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   edge_count_timer dut (
      .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic set_cap(input logic v);
      @(negedge clk);
      cap_in = v;
      repeat (5) @(negedge clk);
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         set_cap(1'b1);
         set_cap(1'b0);
      end
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      rd(3'd3, v); chk("R10 reset count", v, 24'h0);
      rd(3'd4, v); chk("R6 reset status", v, 24'h0);
      rd(3'd0, v); chk("R2 reset control", v, 24'h0);
      chk("R6 reset irq", {23'd0, irq}, 24'h0);
   endtask

   task automatic t_down();
      logic [W-1:0] v;
      wr(3'd0, 24'h0);
      wr(3'd1, 24'h010005);
      rd(3'd3, v); chk("R10 R8 combined load visible", v, 24'h010005);
      wr(3'd2, 24'h010002);
      wr(3'd5, 24'h1);
      wr(3'd0, 24'h1);
      pulse(1); rd(3'd3, v); chk("R12 one transition one step", v, 24'h010004);
      pulse(1); rd(3'd3, v); chk("R1 second edge", v, 24'h010003);
      rd(3'd4, v); chk("R1 no early match", v, 24'h0);
      pulse(1);
      rd(3'd4, v); chk("R1 R6 status at match", v, 24'h1);
      chk("R6 irq at match", {23'd0, irq}, 24'h1);
      rd(3'd3, v); chk("R2 reload on match", v, 24'h010005);
      rd(3'd0, v); chk("R2 run cleared", v & 24'h1, 24'h0);
      pulse(2); rd(3'd3, v); chk("R3 edges ignored when stopped", v, 24'h010005);
      wr(3'd6, 24'h1);
      rd(3'd4, v); chk("R6 write-one clears", v, 24'h0);
      chk("R6 irq after clear", {23'd0, irq}, 24'h0);
      wr(3'd0, 24'h1);
      pulse(1); rd(3'd3, v); chk("R3 counting resumes", v, 24'h010004);
   endtask

   task automatic t_locked();
      logic [W-1:0] v;
      wr(3'd1, 24'h000050);
      rd(3'd3, v); chk("R5 load ignored while running", v, 24'h010004);
      wr(3'd2, 24'h010003);
      rd(3'd2, v); chk("R5 match ignored while running", v, 24'h010002);
      pulse(1);
      rd(3'd4, v); chk("R5 old match still used", v, 24'h0);
      pulse(1);
      rd(3'd3, v); chk("R5 old load used at reload", v, 24'h010005);
      wr(3'd6, 24'h1);
   endtask

   task automatic t_idle();
      logic [W-1:0] v;
      wr(3'd0, 24'h1);
      cap_in = 1'b1;
      repeat (300) @(negedge clk);
      rd(3'd3, v); chk("R9 constant high input no change", v, 24'h010004);
      wr(3'd0, 24'h0);
      repeat (300) @(negedge clk);
      rd(3'd3, v); chk("R9 R3 held after stop", v, 24'h010004);
      set_cap(1'b0);
   endtask

   task automatic t_edge_sel();
      logic [W-1:0] v;
      wr(3'd0, 24'h4);
      wr(3'd1, 24'd20);
      wr(3'd2, 24'd0);
      wr(3'd0, 24'h5);
      set_cap(1'b1); rd(3'd3, v); chk("R7 falling mode ignores rise", v, 24'd20);
      set_cap(1'b0); rd(3'd3, v); chk("R7 falling mode counts fall", v, 24'd19);
      wr(3'd0, 24'h4);
      wr(3'd0, 24'h8);
      wr(3'd0, 24'h9);
      pulse(1); rd(3'd3, v); chk("R7 both edges count", v, 24'd17);
      wr(3'd0, 24'h8);
   endtask

   task automatic t_up();
      logic [W-1:0] v;
      wr(3'd0, 24'h2);
      rd(3'd3, v); chk("R4 up mode starts at zero", v, 24'd0);
      wr(3'd2, 24'd3);
      wr(3'd0, 24'h3);
      pulse(2); rd(3'd3, v); chk("R4 up counting", v, 24'd2);
      pulse(1);
      rd(3'd3, v); chk("R4 wrap to zero", v, 24'd0);
      rd(3'd4, v); chk("R4 status on up match", v, 24'h1);
      rd(3'd0, v); chk("R4 run stays set", v & 24'h1, 24'h1);
      pulse(1); rd(3'd3, v); chk("R4 keeps counting", v, 24'd1);
      wr(3'd6, 24'h1);
      wr(3'd0, 24'h2);
   endtask

   task automatic t_defer();
      logic [W-1:0] v;
      wr(3'd0, 24'h0);
      wr(3'd1, 24'd6);
      rd(3'd3, v); chk("R8 immediate load", v, 24'd6);
      wr(3'd2, 24'd4);
      wr(3'd0, 24'h10);
      wr(3'd1, 24'd9);
      rd(3'd3, v); chk("R8 deferred load held", v, 24'd6);
      wr(3'd0, 24'h11);
      pulse(2);
      rd(3'd4, v); chk("R8 match with old load", v, 24'h1);
      rd(3'd3, v); chk("R8 deferred load applied at reload", v, 24'd9);
      wr(3'd6, 24'h1);
      wr(3'd0, 24'h11);
      pulse(4);
      rd(3'd3, v); chk("R1 count before match", v, 24'd5);
      rd(3'd4, v); chk("R1 no match yet", v, 24'h0);
      pulse(1);
      rd(3'd4, v); chk("R1 match after load minus match edges", v, 24'h1);
      wr(3'd6, 24'h1);
   endtask

   task automatic t_race();
      logic [W-1:0] v;
      wr(3'd0, 24'h0);
      wr(3'd1, 24'd2);
      wr(3'd2, 24'd0);
      wr(3'd0, 24'h1);
      pulse(1);
      rd(3'd4, v); chk("R11 status clear before race", v, 24'h0);
      @(negedge clk); cap_in = 1'b1;
      repeat (2) @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 24'h1;
      @(negedge clk); reg_wr = 1'b0;
      rd(3'd4, v); chk("R11 match beats same-cycle clear", v, 24'h1);
      chk("R11 irq stays asserted", {23'd0, irq}, 24'h1);
      set_cap(1'b0);
      wr(3'd6, 24'h1);
      rd(3'd4, v); chk("R6 later clear works", v, 24'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_down();
      t_locked();
      t_idle();
      t_edge_sel();
      t_up();
      t_defer();
      t_race();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule